// File: doc/BRIEF.md
# Configuration Request PIO Engine

This block lets a host issue single PCIe configuration reads and writes through a small bank of registers. Software sets the access direction, size, root bus number and target (bus, device, function, register offset). It places write data in the data register and then writes the start register. The engine works out the request code and the byte strobe and packs the link address. It then presents exactly one request to a link-side agent and waits for that agent's completion.

When the completion arrives, the engine records a packed status word. On a successful read it also records the returned data. It then drops the start indication and raises a sticky done flag. Some failures are handled locally. A target device other than 0 on the root bus is refused without touching the link. A start written while a transfer is outstanding is ignored and raises a sticky busy-error flag. Configuration-retry completions on reads can optionally be turned into a fixed placeholder value and treated as success.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset every host register reads 0 and `req_valid` is low.
- R2: On each accepted start, the request code is `{2'b10, write, type1}`: read Type 0 = 0x8, read Type 1 = 0x9, write Type 0 = 0xA, write Type 1 = 0xB. Type 0 is chosen exactly when the target bus equals the root bus in CTRL[15:8]. The code appears on `req_kind` and in CTRL[3:0].
- R3: TARGET holds bus in [27:20], device in [19:15], function in [14:12] and offset in [11:0]. `req_addr` carries bus, device and function in those positions, with the offset masked by 0xFFC, and zeros elsewhere.
- R4: The size code is in CTRL[6:5], with 0 for byte, 1 for halfword and 2 or 3 for word. The strobe is 0x1, 0x3 or 0xF, shifted left by offset[1:0] and truncated to 4 bits. It appears on `req_strb` and in the STRB register (index 3).
- R5: Writing 1 to START (index 4) while idle issues one `req_valid` pulse of a single cycle. START reads 1 until the completion is accepted and 0 afterwards. ISR bit 0 (index 5) is then set. It stays set until 1 is written to ISR bit 0.
- R6: The STATUS register (index 6) holds the completion code in [9:7] (OK=0, UR=1, CRS=2, CA=4), 1 in [10] for a non-posted request, the completion error flag in [11], and a failure summary in [12]. An access succeeds only for OK without the error flag, or for CRS on a read when CTRL[7] allows it. Every other outcome, unknown codes included, is a failure.
- R7: A successful OK read stores the completion data in RDATA (index 7). A failed read stores 0xFFFFFFFF. Write completions leave RDATA unchanged.
- R8: A CRS completion on a read with CTRL[7]=1 stores 0xFFFF0001 in RDATA and reports success.
- R9: A nonzero device on the root bus is refused and no request is issued. The done flag is set one cycle after the start, and STATUS reads 0. A refused read stores all ones for its size (0xFF, 0xFFFF or 0xFFFFFFFF). A refused write leaves RDATA unchanged.
- R10: A start written while a transfer is outstanding issues no request and sets ISR bit 1. That bit is sticky until 1 is written to ISR bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_addr | input | 3 | Host register index |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| req_valid | output | 1 | One-cycle request pulse to the link agent |
| req_kind | output | 4 | Request code |
| req_addr | output | 32 | Packed configuration address |
| req_wdata | output | 32 | Write data (lane-aligned by software) |
| req_strb | output | 4 | Byte strobe |
| cpl_valid | input | 1 | Completion present for one cycle |
| cpl_status | input | 3 | Completion code |
| cpl_err | input | 1 | Completion error flag |
| cpl_data | input | 32 | Completion read data |

## Verification
The assertions assume the link agent returns exactly one completion for each request, only while a transfer is outstanding, and never in the same cycle as the request. The bench's link model answers a fixed number of cycles after it sees `req_valid`, and only in response to one. The host side is assumed not to clear the done flag in the same cycle as a completion. The bench clears it only before it writes START, and it pokes START a second time only while the link model is still waiting.

// File: rtl/cfgpio_pkg.sv
// Shared encodings for the configuration request PIO engine.
// Assumes a 3-bit host register index and 32-bit host data.
package cfgpio_pkg;
    typedef enum logic [2:0] {
        R_CTRL   = 3'd0,
        R_TARGET = 3'd1,
        R_WDATA  = 3'd2,
        R_STRB   = 3'd3,
        R_START  = 3'd4,
        R_ISR    = 3'd5,
        R_STATUS = 3'd6,
        R_RDATA  = 3'd7
    } reg_idx_e;

    localparam logic [2:0] CPL_OK  = 3'd0;
    localparam logic [2:0] CPL_UR  = 3'd1;
    localparam logic [2:0] CPL_CRS = 3'd2;
    localparam logic [2:0] CPL_CA  = 3'd4;

    localparam logic [31:0] CRS_FAKE = 32'hFFFF_0001;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    // Status word bit positions
    localparam int ST_CODE_LO = 7;
    localparam int ST_NP_BIT  = 10;
    localparam int ST_ERR_BIT = 11;
    localparam int ST_FAIL_BIT = 12;

    // Control register field positions
    localparam int CT_WR_BIT    = 4;
    localparam int CT_SIZE_LO   = 5;
    localparam int CT_ALLOW_BIT = 7;
    localparam int CT_ROOT_LO   = 8;
endpackage

// File: rtl/cfgpio_req_build.sv
// Request builder: derives request code, link address, byte strobe and the
// local-refusal decision from the programmed target and control fields.
// Purely combinational; assumes STRB_W is a power of two.
module cfgpio_req_build #(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter int STRB_W = 4
) (
    input  logic [DATA_W-1:0] target,
    input  logic [BUS_W-1:0]  root_bus,
    input  logic              is_wr,
    input  logic [1:0]        size,
    output logic [3:0]        kind,
    output logic [DATA_W-1:0] link_addr,
    output logic [STRB_W-1:0] strb,
    output logic              refuse,
    output logic [DATA_W-1:0] size_ones
);
    import cfgpio_pkg::*;

    localparam int FN_LO  = OFF_W;
    localparam int DEV_LO = FN_LO + FN_W;
    localparam int BUS_LO = DEV_LO + DEV_W;
    localparam int BUS_HI = BUS_LO + BUS_W - 1;
    localparam int LANE_W = $clog2(STRB_W);

    logic [BUS_W-1:0]    f_bus;
    logic [DEV_W-1:0]    f_dev;
    logic [STRB_W-1:0]   base_mask;
    logic [2*STRB_W-1:0] shifted;
    logic                type1;

    // Field extraction and type selection
    always_comb begin
        f_bus  = target[BUS_HI:BUS_LO];
        f_dev  = target[DEV_LO+DEV_W-1:DEV_LO];
        type1  = (f_bus != root_bus);
        refuse = !type1 && (f_dev != '0);
        kind   = {2'b10, is_wr, type1};
    end

    // Link address: routing fields kept, offset dword-aligned, rest zero
    always_comb begin
        link_addr = '0;
        link_addr[BUS_HI:FN_LO] = target[BUS_HI:FN_LO];
        link_addr[OFF_W-1:LANE_W] = target[OFF_W-1:LANE_W];
    end

    // Byte strobe from size, shifted by the lane offset
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: base_mask = STRB_W'(1);
            SZ_HALF: base_mask = STRB_W'(3);
            default: base_mask = '1;
        endcase
        shifted = {{STRB_W{1'b0}}, base_mask} << target[LANE_W-1:0];
        strb    = shifted[STRB_W-1:0];
    end

    // All-ones value of the access width, returned by a refused read
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: size_ones = DATA_W'(8'hFF);
            SZ_HALF: size_ones = DATA_W'(16'hFFFF);
            default: size_ones = '1;
        endcase
    end
endmodule

// File: rtl/cfgpio_cpl_eval.sv
// Completion evaluator: classifies a completion as success or failure,
// selects the value to store as read data and packs the status word.
// Combinational; assumes direction and CRS policy are those of the transfer.
module cfgpio_cpl_eval #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        cpl_status,
    input  logic              cpl_err,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic              is_wr,
    input  logic              allow_crs,
    output logic              success,
    output logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] stat_word
);
    import cfgpio_pkg::*;

    logic crs_ok;

    // Outcome classification
    always_comb begin
        crs_ok  = (cpl_status == CPL_CRS) && allow_crs && !is_wr;
        success = ((cpl_status == CPL_OK) && !cpl_err) || crs_ok;
    end

    // Value destined for the read-data register
    always_comb begin
        if (!success)
            rd_value = '1;
        else if (crs_ok)
            rd_value = DATA_W'(CRS_FAKE);
        else
            rd_value = cpl_data;
    end

    // Status word packing
    always_comb begin
        stat_word = '0;
        stat_word[ST_CODE_LO+2:ST_CODE_LO] = cpl_status;
        stat_word[ST_NP_BIT]   = 1'b1;
        stat_word[ST_ERR_BIT]  = cpl_err;
        stat_word[ST_FAIL_BIT] = !success;
    end
endmodule

// File: rtl/cfgpio_seq.sv
// Transfer sequencer: tracks the outstanding transfer, issues the single
// request pulse, and keeps the sticky done and busy-error flags.
// Assumes at most one completion per request, only while busy.
module cfgpio_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic refuse,
    input  logic cpl_valid,
    input  logic clr_done,
    input  logic clr_berr,
    output logic accept,
    output logic finish,
    output logic busy_q,
    output logic done_q,
    output logic berr_q,
    output logic req_q
);
    // Start acceptance and completion acceptance
    always_comb begin
        accept = start_req && !busy_q;
        finish = busy_q && cpl_valid;
    end

    // Outstanding-transfer flag and request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= accept && !refuse;
            if (accept && !refuse)
                busy_q <= 1'b1;
            else if (finish)
                busy_q <= 1'b0;
        end
    end

    // Sticky done flag: setting wins over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (finish || (accept && refuse))
            done_q <= 1'b1;
        else if (clr_done)
            done_q <= 1'b0;
    end

    // Sticky busy-error flag for starts written while busy
    always_ff @(posedge clk) begin
        if (!rst_n)
            berr_q <= 1'b0;
        else if (start_req && busy_q)
            berr_q <= 1'b1;
        else if (clr_berr)
            berr_q <= 1'b0;
    end
endmodule

// File: rtl/cfg_pio_engine.sv
// Configuration request PIO engine top: host register bank, latching of
// request fields at start, and capture of completion results.
// Assumes host writes take effect on the clock edge where hst_wr_en is high
// and that reads are combinational on hst_addr.
module cfg_pio_engine #(
    parameter int BUS_W  = 8,
    parameter int DEV_W  = 5,
    parameter int FN_W   = 3,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter int STRB_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_wr_en,
    input  logic [2:0]        hst_addr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              req_valid,
    output logic [3:0]        req_kind,
    output logic [DATA_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [STRB_W-1:0] req_strb,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_status,
    input  logic              cpl_err,
    input  logic [DATA_W-1:0] cpl_data
);
    import cfgpio_pkg::*;

    localparam int ROOT_HI = CT_ROOT_LO + BUS_W - 1;

    // Control fields
    logic             ctl_wr, ctl_allow;
    logic [1:0]       ctl_size;
    logic [BUS_W-1:0] ctl_root;
    logic [3:0]       ctl_kind;
    logic [DATA_W-1:0] target_q, wdata_q, status_q, rdata_q;
    logic [STRB_W-1:0] strb_q;
    logic             xfer_wr, xfer_allow;

    // Host decode
    logic wr_ctrl, wr_target, wr_wdata, wr_isr;
    logic start_req, clr_done, clr_berr;

    // Builder / evaluator / sequencer nets
    logic [3:0]        b_kind;
    logic [DATA_W-1:0] b_addr, b_ones;
    logic [STRB_W-1:0] b_strb;
    logic              reject;
    logic              e_success;
    logic [DATA_W-1:0] e_rd, e_stat;
    logic              accept, finish, busy_q, done_q, berr_q;

    // Host write decode
    always_comb begin
        wr_ctrl   = hst_wr_en && (hst_addr == R_CTRL);
        wr_target = hst_wr_en && (hst_addr == R_TARGET);
        wr_wdata  = hst_wr_en && (hst_addr == R_WDATA);
        wr_isr    = hst_wr_en && (hst_addr == R_ISR);
        start_req = hst_wr_en && (hst_addr == R_START) && hst_wdata[0];
        clr_done  = wr_isr && hst_wdata[0];
        clr_berr  = wr_isr && hst_wdata[1];
    end

    cfgpio_req_build #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W),
        .DATA_W(DATA_W), .STRB_W(STRB_W)
    ) u_build (
        .target   (target_q),
        .root_bus (ctl_root),
        .is_wr    (ctl_wr),
        .size     (ctl_size),
        .kind     (b_kind),
        .link_addr(b_addr),
        .strb     (b_strb),
        .refuse   (reject),
        .size_ones(b_ones)
    );

    cfgpio_cpl_eval #(.DATA_W(DATA_W)) u_eval (
        .cpl_status(cpl_status),
        .cpl_err   (cpl_err),
        .cpl_data  (cpl_data),
        .is_wr     (xfer_wr),
        .allow_crs (xfer_allow),
        .success   (e_success),
        .rd_value  (e_rd),
        .stat_word (e_stat)
    );

    cfgpio_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .refuse   (reject),
        .cpl_valid(cpl_valid),
        .clr_done (clr_done),
        .clr_berr (clr_berr),
        .accept   (accept),
        .finish   (finish),
        .busy_q   (busy_q),
        .done_q   (done_q),
        .berr_q   (berr_q),
        .req_q    (req_valid)
    );

    // Software-written registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_wr    <= 1'b0;
            ctl_allow <= 1'b0;
            ctl_size  <= 2'd0;
            ctl_root  <= '0;
            target_q  <= '0;
            wdata_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl_wr    <= hst_wdata[CT_WR_BIT];
                ctl_size  <= hst_wdata[CT_SIZE_LO+1:CT_SIZE_LO];
                ctl_allow <= hst_wdata[CT_ALLOW_BIT];
                ctl_root  <= hst_wdata[ROOT_HI:CT_ROOT_LO];
            end
            if (wr_target) target_q <= hst_wdata;
            if (wr_wdata)  wdata_q  <= hst_wdata;
        end
    end

    // Per-transfer snapshot taken when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_kind   <= 4'd0;
            strb_q     <= '0;
            req_kind   <= 4'd0;
            req_addr   <= '0;
            req_wdata  <= '0;
            req_strb   <= '0;
            xfer_wr    <= 1'b0;
            xfer_allow <= 1'b0;
        end else if (accept) begin
            ctl_kind   <= b_kind;
            strb_q     <= b_strb;
            req_kind   <= b_kind;
            req_addr   <= b_addr;
            req_wdata  <= wdata_q;
            req_strb   <= b_strb;
            xfer_wr    <= ctl_wr;
            xfer_allow <= ctl_allow;
        end
    end

    // Result capture on completion or local refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            rdata_q  <= '0;
        end else if (finish) begin
            status_q <= e_stat;
            if (!xfer_wr) rdata_q <= e_rd;
        end else if (accept && reject) begin
            status_q <= '0;
            if (!ctl_wr) rdata_q <= b_ones;
        end
    end

    // Host read multiplexer
    always_comb begin
        hst_rdata = '0;
        case (reg_idx_e'(hst_addr))
            R_CTRL: begin
                hst_rdata[3:0]                 = ctl_kind;
                hst_rdata[CT_WR_BIT]           = ctl_wr;
                hst_rdata[CT_SIZE_LO+1:CT_SIZE_LO] = ctl_size;
                hst_rdata[CT_ALLOW_BIT]        = ctl_allow;
                hst_rdata[ROOT_HI:CT_ROOT_LO]  = ctl_root;
            end
            R_TARGET: hst_rdata = target_q;
            R_WDATA:  hst_rdata = wdata_q;
            R_STRB:   hst_rdata[STRB_W-1:0] = strb_q;
            R_START:  hst_rdata[0] = busy_q;
            R_ISR:    hst_rdata[1:0] = {berr_q, done_q};
            R_STATUS: hst_rdata = status_q;
            R_RDATA:  hst_rdata = rdata_q;
            default:  hst_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgpio_checker.sv
// Protocol checker for cfg_pio_engine, attached by bind.
// Assumes completions arrive only while a transfer is outstanding.
module cfgpio_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] req_kind,
    input logic [3:0] req_strb,
    input logic       cpl_valid,
    input logic       start_req,
    input logic       accept,
    input logic       reject,
    input logic       busy_q,
    input logic       done_q,
    input logic       berr_q
);
    // R5: request is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R5: a request is always backed by an outstanding transfer
    a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy_q);

    // R5: an accepted completion ends the transfer and raises done
    a_r5_cpl_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cpl_valid) |=> (done_q && !busy_q));

    // R2: request codes are all configuration codes 0x8..0xB
    a_r2_kind_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_kind[3:2] == 2'b10));

    // R4: a request always enables at least one byte lane
    a_r4_strb_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_strb != 4'b0000));

    // R9: a refused start never reaches the link and completes at once
    a_r9_refuse_local: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reject) |=> (!req_valid && done_q));

    // R10: a start while busy issues nothing and flags the error
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && busy_q) |=> (!req_valid && berr_q));
endmodule

bind cfg_pio_engine cfgpio_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .req_strb (req_strb),
    .cpl_valid(cpl_valid),
    .start_req(start_req),
    .accept   (accept),
    .reject   (reject),
    .busy_q   (busy_q),
    .done_q   (done_q),
    .berr_q   (berr_q)
);

// File: tb/sim_cfg_pio_engine.sv
// Scoreboard bench: the driver queues expected link requests, a monitor
// compares them with req_* as they appear, a link model answers each request.
module sim_cfg_pio_engine;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 6;
    localparam logic [2:0] I_CTRL = 0, I_TGT = 1, I_WD = 2, I_STRB = 3,
                           I_START = 4, I_ISR = 5, I_STAT = 6, I_RD = 7;

    logic        clk = 0, rst_n = 0;
    logic        hst_wr_en = 0;
    logic [2:0]  hst_addr = 0;
    logic [31:0] hst_wdata = 0, hst_rdata;
    logic        req_valid;
    logic [3:0]  req_kind, req_strb;
    logic [31:0] req_addr, req_wdata;
    logic        cpl_valid = 0, cpl_err = 0;
    logic [2:0]  cpl_status = 0;
    logic [31:0] cpl_data = 0;

    logic [2:0]  rsp_stat = 0;
    logic        rsp_err = 0;
    logic [31:0] rsp_data = 0;
    logic [31:0] model_rd = 0;

    int checks = 0, errors = 0;
    bit ended = 0;
    logic [71:0] exp_q[$];

    cfg_pio_engine u0 (
        .clk(clk), .rst_n(rst_n), .hst_wr_en(hst_wr_en), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_strb(req_strb), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .cpl_err(cpl_err), .cpl_data(cpl_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Link model: answer each request after LAT cycles
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                repeat (LAT) @(negedge clk);
                cpl_valid = 1; cpl_status = rsp_stat; cpl_err = rsp_err; cpl_data = rsp_data;
                @(negedge clk);
                cpl_valid = 0;
            end
        end
    end

    // Monitor: compare each request with the next expected item
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid && rst_n) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9/R10 unexpected request: actual kind %h expected none", req_kind);
                end else begin
                    logic [71:0] it;
                    it = exp_q.pop_front();
                    check("R2 req_kind", {28'd0, req_kind}, {28'd0, it[71:68]});
                    check("R3 req_addr", req_addr, it[67:36]);
                    check("R4 req_strb", {28'd0, req_strb}, {28'd0, it[35:32]});
                    check("R5 req_wdata", req_wdata, it[31:0]);
                end
            end
        end
    end

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_wr_en = 1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr_en = 0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] d);
        hst_addr = a;
        #1 d = hst_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s, i;
        ok = 0;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            hread(I_START, s);
            hread(I_ISR, i);
            if (s[0] == 0 && i[0]) begin ok = 1; break; end
        end
    endtask

    // One full transfer with all expectations computed here
    task automatic xfer(input logic [7:0] root, input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] fn, input logic [11:0] off, input logic [1:0] size,
                        input bit wr, input bit allow, input logic [31:0] wd,
                        input logic [2:0] cs, input bit ce, input logic [31:0] cd, input bit poke);
        logic [3:0]  ekind;
        logic [31:0] eaddr, estat, v;
        logic [7:0]  m8;
        logic [3:0]  estrb;
        bit refuse, ok, succ;
        refuse = (bus == root) && (dev != 0);
        ekind = {2'b10, wr, bus != root};
        eaddr = {4'd0, bus, dev, fn, off[11:2], 2'b00};
        m8 = {4'd0, (size == 0) ? 4'h1 : (size == 1) ? 4'h3 : 4'hF} << off[1:0];
        estrb = m8[3:0];
        rsp_stat = cs; rsp_err = ce; rsp_data = cd;
        hwrite(I_CTRL, {16'd0, root, allow, size, wr, 4'd0});
        hwrite(I_TGT, {4'd0, bus, dev, fn, off});
        hwrite(I_WD, wd);
        hwrite(I_ISR, 32'h1);
        if (!refuse) exp_q.push_back({ekind, eaddr, estrb, wd});
        hwrite(I_START, 32'h1);
        if (poke) begin
            hwrite(I_START, 32'h1);
            hread(I_START, v); check("R5 start reads 1 while busy", v, 32'h1);
            hread(I_ISR, v);   check("R10 busy-error set", {31'd0, v[1]}, 32'h1);
        end
        wait_done(ok);
        check("R5 transfer completes", {31'd0, ok}, 32'h1);
        hread(I_CTRL, v); check("R2 ctrl kind", {28'd0, v[3:0]}, {28'd0, ekind});
        hread(I_STRB, v); check("R4 strb reg", v, {28'd0, estrb});
        if (refuse) begin
            hread(I_STAT, v); check("R9 status zero", v, 32'h0);
            if (!wr) model_rd = (size == 0) ? 32'hFF : (size == 1) ? 32'hFFFF : 32'hFFFFFFFF;
            hread(I_RD, v); check("R9 refused rdata", v, model_rd);
        end else begin
            succ = (cs == 0 && !ce) || (cs == 2 && allow && !wr);
            estat = {19'd0, !succ, ce, 1'b1, cs, 7'd0};
            hread(I_STAT, v); check("R6 status word", v, estat);
            if (!wr) model_rd = !succ ? 32'hFFFFFFFF : (cs == 2) ? 32'hFFFF0001 : cd;
            hread(I_RD, v); check("R7/R8 rdata", v, model_rd);
        end
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int r = 0; r < 8; r++) begin
            hread(3'(r), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 req_valid low", {31'd0, req_valid}, 32'h0);

        // R2/R3 Type 0 read, OK
        xfer(8'h02, 8'h02, 5'd0, 3'd5, 12'h0A4, 2'd2, 0, 0, 32'h0, 3'd0, 0, 32'hCAFE1234, 0);
        // R2/R4 Type 1 read, byte at lane 3
        xfer(8'h02, 8'h7E, 5'd31, 3'd7, 12'hF13, 2'd0, 0, 0, 32'h0, 3'd0, 0, 32'h11223344, 0);
        // R4 Type 0 write, halfword lane 2; R7 rdata unchanged
        xfer(8'h00, 8'h00, 5'd0, 3'd1, 12'h042, 2'd1, 1, 0, 32'hBEEF0000, 3'd0, 0, 32'h0, 0);
        // R2 Type 1 write, word
        xfer(8'h00, 8'h55, 5'd3, 3'd0, 12'h3FC, 2'd2, 1, 0, 32'h01020304, 3'd0, 0, 32'h0, 0);
        // R4 word at lane 1 truncated
        xfer(8'h00, 8'h09, 5'd1, 3'd0, 12'h001, 2'd3, 1, 0, 32'h5, 3'd0, 0, 32'h0, 0);
        // R6/R7 failures on reads: UR, OK with error, CA, unknown
        xfer(8'h00, 8'h01, 5'd0, 3'd0, 12'h010, 2'd2, 0, 0, 32'h0, 3'd1, 0, 32'h1, 0);
        xfer(8'h00, 8'h01, 5'd0, 3'd0, 12'h010, 2'd2, 0, 0, 32'h0, 3'd0, 1, 32'h2, 0);
        xfer(8'h00, 8'h01, 5'd0, 3'd0, 12'h010, 2'd2, 0, 1, 32'h0, 3'd4, 0, 32'h3, 0);
        xfer(8'h00, 8'h01, 5'd0, 3'd0, 12'h010, 2'd2, 0, 1, 32'h0, 3'd5, 0, 32'h4, 0);
        // R8 CRS allowed on read, then not allowed, then on write
        xfer(8'h00, 8'h00, 5'd0, 3'd0, 12'h000, 2'd2, 0, 1, 32'h0, 3'd2, 0, 32'h9, 0);
        xfer(8'h00, 8'h00, 5'd0, 3'd0, 12'h000, 2'd2, 0, 0, 32'h0, 3'd2, 0, 32'h9, 0);
        xfer(8'h00, 8'h00, 5'd0, 3'd0, 12'h000, 2'd2, 1, 1, 32'h7, 3'd2, 0, 32'h9, 0);
        // R7 good read then write leaves data
        xfer(8'h00, 8'h04, 5'd2, 3'd2, 12'h008, 2'd2, 0, 0, 32'h0, 3'd0, 0, 32'hA5A5A5A5, 0);
        xfer(8'h00, 8'h04, 5'd2, 3'd2, 12'h008, 2'd2, 1, 0, 32'h77, 3'd0, 0, 32'h0, 0);
        // R9 refusals: byte read, half read, write, word read
        xfer(8'h03, 8'h03, 5'd1, 3'd0, 12'h000, 2'd0, 0, 0, 32'h0, 3'd0, 0, 32'h0, 0);
        xfer(8'h03, 8'h03, 5'd9, 3'd0, 12'h002, 2'd1, 0, 0, 32'h0, 3'd0, 0, 32'h0, 0);
        xfer(8'h03, 8'h03, 5'd9, 3'd0, 12'h002, 2'd2, 1, 0, 32'h0, 3'd0, 0, 32'h0, 0);
        xfer(8'h03, 8'h03, 5'd2, 3'd0, 12'h000, 2'd2, 0, 0, 32'h0, 3'd0, 0, 32'h0, 0);
        // R10 start while busy
        xfer(8'h00, 8'h06, 5'd0, 3'd0, 12'h020, 2'd2, 0, 0, 32'h0, 3'd0, 0, 32'h600DF00D, 1);
        // R5 done persists, then clears; R10 busy-error sticky then clears
        repeat (5) @(negedge clk);
        hread(I_ISR, v); check("R5 done persists", {31'd0, v[0]}, 32'h1);
        check("R10 busy-error sticky", {31'd0, v[1]}, 32'h1);
        hwrite(I_ISR, 32'h1);
        hread(I_ISR, v); check("R5 done cleared", v, 32'h2);
        hwrite(I_ISR, 32'h2);
        hread(I_ISR, v); check("R10 busy-error cleared", v, 32'h0);
        check("R5 no leftover expected requests", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule